// File: doc/BRIEF.md
# Programmable down-counter timer channel

This block is a single timer channel for a peripheral subsystem. It counts down by one on each pulse of a clock enable that it derives from its own clock through a selectable prescaler. The count can be 16 or 32 bits wide. The channel can run in three ways: free-running, where it wraps to all ones; periodic, where it reloads from a programmed value; or one-shot, where it stops after reaching zero once. When the count steps down to zero, the channel raises a raw interrupt flag. An enable bit in the control word masks that flag before it is driven on the interrupt output.

A bus decoder in the parent design drives the channel through single-cycle write strobes, all sharing one 32-bit write data bus. One strobe loads the value and the count together. A second sets only the reload value. A third writes the control word, and a fourth clears the interrupt. The count, the reload value, the control word and both interrupt levels come out as plain outputs, so the decoder can read them back. A write takes effect at the clock edge on which its strobe is high. Reset is asynchronous and active low, and the reset tree is expected to release it synchronously to the clock.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word reads 0x20, the reload value reads 0, the count reads 0xFFFFFFFF and both interrupt outputs are low. The channel does not count until it is enabled.
- R2: The control word keeps these fields: bit 7 enable, bit 6 periodic (1) or free-running (0), bit 5 interrupt enable, bits 3:2 prescale code, bit 1 width (1 = 32-bit, 0 = 16-bit) and bit 0 one-shot. Bit 4 always reads 0, and data bits above bit 7 are ignored.
- R3: Prescale code 0 gives a decrement every cycle, code 1 every 16 cycles and code 2 every 256 cycles. Code 3 behaves exactly like code 2. The prescaler phase returns to zero on a LOAD write or on a control write that changes the prescale code. After such a restart, the first decrement comes N cycles after the channel starts running.
- R4: A LOAD write sets both the reload value and the count to the write data at that edge, and it takes precedence over a decrement in the same cycle. A BGLOAD write sets only the reload value and leaves the count alone.
- R5: Free-running mode: a tick at a count of zero wraps the count. In 32-bit mode it wraps to 0xFFFFFFFF. In 16-bit mode the low half becomes 0xFFFF and the upper half is kept.
- R6: Periodic mode: a tick at a count of zero reloads the count from the reload value. In 16-bit mode only the low half is reloaded, from the low half of the reload value, and the upper half of the count is kept.
- R7: The raw flag sets on a tick that steps the count, at the active width, from 1 to 0. A wrap or a reload does not set it. A clear strobe resets the flag, but if a set happens in the same cycle the set wins.
- R8: The masked interrupt output is high exactly when the raw flag is high and bit 5 of the control word is set.
- R9: In 16-bit mode the count decrements without borrowing into bits 31:16. In 32-bit mode a borrow from the low half carries into the upper half.
- R10: One-shot mode: after the step to zero, the count stays at zero and the flag does not fire again. Either a control write with bit 7 set or a nonzero LOAD write starts the channel again.
- R11: Periodic mode: a LOAD write whose value is zero at the active width stops the counter. It stays stopped until a control write with bit 7 set.
- R12: While bit 7 is clear, both the count and the prescaler phase are frozen. After re-enabling, counting resumes from the held phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 32 | Write data shared by all strobes |
| load_we | input | 1 | Write reload value and count |
| bgload_we | input | 1 | Write reload value only |
| ctrl_we | input | 1 | Write control word from wr_data[7:0] |
| intclr_we | input | 1 | Clear the raw interrupt flag |
| count_o | output | 32 | Current count (all 32 stored bits) |
| load_o | output | 32 | Reload value |
| ctrl_o | output | 8 | Control word |
| irq_raw_o | output | 1 | Raw interrupt flag |
| irq_masked_o | output | 1 | Raw flag gated by interrupt enable |

## Verification
A wrong prescaler phase makes the count step early or late. At codes 1 to 3 that error shows on count_o within one prescale period of the enable edge. A wrong width or mode decision first shows at a zero crossing: the cycle after zero, the upper half of the count or the wrapped value is wrong, and it can be read at once. A stale stop state shows up as a count that does not move, or as a second interrupt after a one-shot expiry. The bench exposes it by changing the reload value while the counter should be stopped and watching for a reload on the very next cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 8;

  typedef struct packed {
    logic       enable;
    logic       periodic;
    logic       irq_en;
    logic       rsvd;
    logic [1:0] presc;
    logic       wide;
    logic       single;
  } tmr_ctrl_t;

  localparam logic [CTRL_W-1:0] CTRL_KEEP  = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SHIFT_MID = 4,
  parameter int SHIFT_HI  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PW = SHIFT_HI;
  localparam logic [PW-1:0] TERM_MID = PW'((1 << SHIFT_MID) - 1);
  localparam logic [PW-1:0] TERM_HI  = {PW{1'b1}};

  logic [PW-1:0] phase_q, phase_d, term;
  logic          at_term;

  always_comb begin
    case (sel)
      2'd0:    term = '0;
      2'd1:    term = TERM_MID;
      default: term = TERM_HI;
    endcase
  end

  assign at_term = (phase_q == term);
  assign tick    = run & at_term;

  always_comb begin
    phase_d = phase_q;
    if (restart)      phase_d = '0;
    else if (run)     phase_d = at_term ? '0 : phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] reload,
  input  logic             wide,
  input  logic             periodic,
  output logic [CNT_W-1:0] count_q,
  output logic             hit_zero
);
  localparam int HI_W = CNT_W - NARROW_W;
  localparam logic [CNT_W-1:0]    ONE_W = 1;
  localparam logic [NARROW_W-1:0] ONE_N = 1;

  logic [CNT_W-1:0]    count_d, dec_val, rel_val;
  logic [NARROW_W-1:0] lo;
  logic [HI_W-1:0]     hi;
  logic                cur_zero, cur_one;

  assign lo = count_q[NARROW_W-1:0];
  assign hi = count_q[CNT_W-1:NARROW_W];

  always_comb begin
    if (wide) begin
      cur_zero = (count_q == '0);
      cur_one  = (count_q == ONE_W);
      dec_val  = count_q - ONE_W;
      rel_val  = periodic ? reload : {CNT_W{1'b1}};
    end else begin
      cur_zero = (lo == '0);
      cur_one  = (lo == ONE_N);
      dec_val  = {hi, lo - ONE_N};
      rel_val  = {hi, periodic ? reload[NARROW_W-1:0] : {NARROW_W{1'b1}}};
    end
  end

  assign hit_zero = tick & cur_one & ~load_we;

  always_comb begin
    count_d = count_q;
    if (load_we)   count_d = wr_data;
    else if (tick) count_d = cur_zero ? rel_val : dec_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= {CNT_W{1'b1}};
    else        count_q <= count_d;
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic irq_en,
  output logic raw_q,
  output logic masked
);
  logic raw_d;

  assign raw_d  = set_ev | (raw_q & ~clr_ev);
  assign masked = raw_q & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int NARROW_W      = 16,
  parameter int PRE_SHIFT_MID = 4,
  parameter int PRE_SHIFT_HI  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              load_we,
  input  logic              bgload_we,
  input  logic              ctrl_we,
  input  logic              intclr_we,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  load_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_raw_o,
  output logic              irq_masked_o
);
  tmr_ctrl_t        ctrl_q, ctrl_d, ctrl_wr;
  logic [CNT_W-1:0] reload_q, reload_d;
  logic             halt_q, halt_d;
  logic             run, tick, hit_zero, pre_restart, wr_zero;

  assign ctrl_wr = tmr_ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_KEEP);

  // Next state of the control word and reload value
  always_comb begin
    ctrl_d   = ctrl_we ? ctrl_wr : ctrl_q;
    reload_d = (load_we | bgload_we) ? wr_data : reload_q;
  end

  // Zero test of a LOAD value at the active width
  assign wr_zero = ctrl_q.wide ? (wr_data == '0)
                               : (wr_data[NARROW_W-1:0] == '0);

  // Stop state: one-shot expiry or zero periodic load
  always_comb begin
    halt_d = halt_q;
    if (ctrl_we && ctrl_wr.enable)        halt_d = 1'b0;
    else if (load_we)                     halt_d = wr_zero ? (ctrl_q.periodic | halt_q) : 1'b0;
    else if (hit_zero && ctrl_q.single)   halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= tmr_ctrl_t'(CTRL_RESET);
      reload_q <= '0;
      halt_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      halt_q   <= halt_d;
    end
  end

  assign run         = ctrl_q.enable & ~halt_q;
  assign pre_restart = load_we | (ctrl_we && (ctrl_wr.presc != ctrl_q.presc));

  tmr_prescaler #(
    .SHIFT_MID (PRE_SHIFT_MID),
    .SHIFT_HI  (PRE_SHIFT_HI)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (pre_restart),
    .sel     (ctrl_q.presc),
    .tick    (tick)
  );

  tmr_counter #(
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load_we  (load_we),
    .wr_data  (wr_data),
    .reload   (reload_q),
    .wide     (ctrl_q.wide),
    .periodic (ctrl_q.periodic),
    .count_q  (count_o),
    .hit_zero (hit_zero)
  );

  tmr_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (hit_zero),
    .clr_ev (intclr_we),
    .irq_en (ctrl_q.irq_en),
    .raw_q  (irq_raw_o),
    .masked (irq_masked_o)
  );

  assign load_o = reload_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  wr_data,
  input logic              load_we,
  input logic              bgload_we,
  input logic              ctrl_we,
  input logic              intclr_we,
  input logic [CNT_W-1:0]  count_o,
  input logic [CNT_W-1:0]  load_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              irq_raw_o,
  input logic              irq_masked_o
);
  // R2: unused control bits never read as one
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ((ctrl_o & ~CTRL_KEEP) == '0));

  // R4: LOAD sets count and reload value
  a_r4_load_both: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> (count_o == $past(wr_data)) && (load_o == $past(wr_data)));

  // R4: BGLOAD leaves the count alone
  a_r4_bgload_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bgload_we && !load_we && !ctrl_o[7]) |=> (count_o == $past(count_o)) && (load_o == $past(wr_data)));

  // R12: disabled channel holds its count
  a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_o[7] && !load_we) |=> $stable(count_o));

  // R7: flag rises only on arrival at zero
  a_r7_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_raw_o) && !$past(load_we)) |-> (count_o[NARROW_W-1:0] == '0));

  // R7: clear wins when no step to zero is possible
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (intclr_we && (count_o[NARROW_W-1:0] != 1)) |=> !irq_raw_o);

  // R8: masked output implies raw flag and enable
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_masked_o |-> (irq_raw_o && ctrl_o[5]));

  logic unused_ok;
  assign unused_ok = &{1'b0, bgload_we};
endmodule

bind tmr_channel tmr_channel_chk #(
  .CNT_W    (CNT_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_data      (wr_data),
  .load_we      (load_we),
  .bgload_we    (bgload_we),
  .ctrl_we      (ctrl_we),
  .intclr_we    (intclr_we),
  .count_o      (count_o),
  .load_o       (load_o),
  .ctrl_o       (ctrl_o),
  .irq_raw_o    (irq_raw_o),
  .irq_masked_o (irq_masked_o)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk, rst_n;
  logic [31:0] wr_data;
  logic        load_we, bgload_we, ctrl_we, intclr_we;
  logic [31:0] count_o, load_o;
  logic [7:0]  ctrl_o;
  logic        irq_raw_o, irq_masked_o;
  int          nvec, nfail;

  tmr_channel u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_data      (wr_data),
    .load_we      (load_we),
    .bgload_we    (bgload_we),
    .ctrl_we      (ctrl_we),
    .intclr_we    (intclr_we),
    .count_o      (count_o),
    .load_o       (load_o),
    .ctrl_o       (ctrl_o),
    .irq_raw_o    (irq_raw_o),
    .irq_masked_o (irq_masked_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 load, 1 bgload, 2 ctrl, 3 intclr
  task automatic strobe(input int kind, input logic [31:0] d);
    wr_data   = d;
    load_we   = (kind == 0);
    bgload_we = (kind == 1);
    ctrl_we   = (kind == 2);
    intclr_we = (kind == 3);
    @(negedge clk);
    load_we = 0; bgload_we = 0; ctrl_we = 0; intclr_we = 0;
  endtask

  task automatic do_load(input logic [31:0] d); strobe(0, d); endtask
  task automatic do_bg(input logic [31:0] d);   strobe(1, d); endtask
  task automatic do_ctrl(input logic [31:0] d); strobe(2, d); endtask
  task automatic do_clr();                      strobe(3, 32'h0); endtask

  task automatic t_reset();
    chk("R1", "ctrl", {24'h0, ctrl_o}, 32'h20);
    chk("R1", "load", load_o, 32'h0);
    chk("R1", "count", count_o, 32'hFFFFFFFF);
    chk("R1", "raw", {31'h0, irq_raw_o}, 0);
    chk("R1", "masked", {31'h0, irq_masked_o}, 0);
    idle(5);
    chk("R1", "idle count", count_o, 32'hFFFFFFFF);
  endtask

  task automatic t_ctrl_fields();
    do_ctrl(32'hFFFFFF7F);
    chk("R2", "ctrl 7F", {24'h0, ctrl_o}, 32'h6F);
    do_ctrl(32'h12345678);
    chk("R2", "ctrl 78", {24'h0, ctrl_o}, 32'h68);
    do_ctrl(32'h20);
  endtask

  task automatic t_loads();
    do_load(32'h00012345);
    chk("R4", "load count", count_o, 32'h00012345);
    chk("R4", "load value", load_o, 32'h00012345);
    do_bg(32'h0000ABCD);
    chk("R4", "bg value", load_o, 32'h0000ABCD);
    chk("R4", "bg count kept", count_o, 32'h00012345);
  endtask

  task automatic t_free16();
    logic [31:0] held;
    do_clr();
    do_load(32'd3);
    do_ctrl(32'hA0);
    idle(2);
    chk("R7", "count 1", count_o, 32'd1);
    chk("R7", "raw before zero", {31'h0, irq_raw_o}, 0);
    idle(1);
    chk("R7", "count 0", count_o, 32'd0);
    chk("R7", "raw at zero", {31'h0, irq_raw_o}, 1);
    chk("R8", "masked with ie", {31'h0, irq_masked_o}, 1);
    idle(1);
    chk("R5", "16-bit wrap", count_o, 32'h0000FFFF);
    do_clr();
    chk("R7", "cleared", {31'h0, irq_raw_o}, 0);
    do_ctrl(32'h20);
    held = count_o;
    idle(5);
    chk("R12", "frozen count", count_o, held);
  endtask

  task automatic t_width();
    do_clr();
    do_load(32'h00030001);
    do_ctrl(32'hA0);
    idle(1);
    chk("R9", "16-bit low zero", count_o, 32'h00030000);
    chk("R7", "16-bit zero sets raw", {31'h0, irq_raw_o}, 1);
    idle(1);
    chk("R9", "16-bit no borrow", count_o, 32'h0003FFFF);
    do_ctrl(32'h22);
    do_load(32'h00050001);
    do_ctrl(32'hA2);
    idle(1);
    chk("R9", "32-bit step", count_o, 32'h00050000);
    idle(1);
    chk("R9", "32-bit borrow", count_o, 32'h0004FFFF);
    do_ctrl(32'h22);
    do_clr();
    do_load(32'd1);
    do_ctrl(32'hA2);
    idle(1);
    chk("R7", "32-bit zero raw", {31'h0, irq_raw_o}, 1);
    do_clr();
    chk("R5", "32-bit wrap", count_o, 32'hFFFFFFFF);
    chk("R7", "wrap does not set", {31'h0, irq_raw_o}, 0);
    do_ctrl(32'h20);
  endtask

  task automatic t_set_wins();
    do_clr();
    do_load(32'd1);
    do_ctrl(32'hA0);
    do_clr();
    chk("R7", "set beats clear", {31'h0, irq_raw_o}, 1);
    chk("R7", "count at zero", count_o, 32'd0);
    do_ctrl(32'h00);
    chk("R8", "masked off", {31'h0, irq_masked_o}, 0);
    chk("R8", "raw kept", {31'h0, irq_raw_o}, 1);
    do_ctrl(32'h20);
    chk("R8", "masked on", {31'h0, irq_masked_o}, 1);
  endtask

  task automatic t_periodic();
    do_clr();
    do_ctrl(32'h60);
    do_load(32'd2);
    do_bg(32'h00070005);
    chk("R4", "bg periodic", load_o, 32'h00070005);
    do_ctrl(32'hE0);
    idle(2);
    chk("R6", "periodic zero", count_o, 32'd0);
    chk("R7", "periodic raw", {31'h0, irq_raw_o}, 1);
    idle(1);
    chk("R6", "periodic reload low half", count_o, 32'h00000005);
    do_ctrl(32'h60);
  endtask

  task automatic t_prescale();
    do_ctrl(32'h04);
    do_load(32'd100);
    do_ctrl(32'h84);
    idle(15);
    chk("R3", "div16 before", count_o, 32'd100);
    idle(1);
    chk("R3", "div16 first", count_o, 32'd99);
    idle(16);
    chk("R3", "div16 second", count_o, 32'd98);
    do_ctrl(32'h08);
    do_load(32'd100);
    do_ctrl(32'h88);
    idle(255);
    chk("R3", "div256 before", count_o, 32'd100);
    idle(1);
    chk("R3", "div256 first", count_o, 32'd99);
    do_ctrl(32'h0C);
    do_load(32'd100);
    do_ctrl(32'h8C);
    idle(255);
    chk("R3", "code3 before", count_o, 32'd100);
    idle(1);
    chk("R3", "code3 first", count_o, 32'd99);
    // R12: prescaler phase held across disable
    do_ctrl(32'h04);
    do_load(32'd100);
    do_ctrl(32'h84);
    idle(10);
    do_ctrl(32'h04);
    idle(20);
    chk("R12", "frozen while off", count_o, 32'd100);
    do_ctrl(32'h84);
    idle(4);
    chk("R12", "phase held before", count_o, 32'd100);
    idle(1);
    chk("R12", "phase held step", count_o, 32'd99);
    do_ctrl(32'h20);
  endtask

  task automatic t_oneshot();
    do_clr();
    do_load(32'd2);
    do_ctrl(32'hA1);
    idle(2);
    chk("R10", "oneshot zero", count_o, 32'd0);
    chk("R10", "oneshot raw", {31'h0, irq_raw_o}, 1);
    do_clr();
    idle(10);
    chk("R10", "oneshot holds", count_o, 32'd0);
    chk("R10", "no refire", {31'h0, irq_raw_o}, 0);
    do_load(32'd3);
    chk("R10", "reload count", count_o, 32'd3);
    idle(3);
    chk("R10", "restart by load", count_o, 32'd0);
    idle(5);
    chk("R10", "halt again", count_o, 32'd0);
    do_clr();
    do_ctrl(32'hA1);
    idle(1);
    chk("R10", "restart by ctrl", count_o, 32'h0000FFFF);
    do_ctrl(32'h20);
  endtask

  task automatic t_zero_stop();
    do_ctrl(32'h60);
    do_load(32'd9);
    do_ctrl(32'hE0);
    do_load(32'h00010000);
    do_bg(32'd5);
    idle(10);
    chk("R11", "stopped count", count_o, 32'h00010000);
    do_ctrl(32'hE0);
    idle(1);
    chk("R11", "resume reload", count_o, 32'h00010005);
    do_ctrl(32'h20);
  endtask

  initial begin
    nvec = 0; nfail = 0;
    rst_n = 0; wr_data = 0;
    load_we = 0; bgload_we = 0; ctrl_we = 0; intclr_we = 0;
    idle(3);
    rst_n = 1;
    idle(1);
    t_reset();
    t_ctrl_fields();
    t_loads();
    t_free16();
    t_width();
    t_set_wins();
    t_periodic();
    t_prescale();
    t_oneshot();
    t_zero_stop();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule